// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Port

This block is a serial slave for a receiver's control processor. It has three signals: a chip-enable, a clock and a data-in line, plus a data-out line that is open-drain at the board level. While chip-enable is low, the host shifts in an 8-bit address. When chip-enable goes high, the data phase begins. In that phase the port does one of two things, depending on the address:
- it collects a 16-bit control word for one of two configuration registers, or
- it streams 32-bit words out of an attached data buffer, one bit per clock, for as many words as the host keeps clocking.

All pins are synchronized into the system clock before any edge is detected. Data-in is taken on clock rising edges and data-out advances on falling edges. The host may idle the clock either high or low.

A configuration write takes effect only when chip-enable falls. Before committing, the port checks the word for reserved bits and illegal field codes. A word that fails the check is dropped whole and raises an error output. The next accepted write clears that error.

Top module: `sctl_port`

## Requirements
- R1: After reset, configuration register 1 reads 0x0902, configuration register 2 reads 0x0034, the error output is 0 and the data-out line is 1.
- R2: While chip-enable is low, each clock rising edge shifts one address bit in, LSB first. The last 8 bits decide the frame: 0x6A selects register 1, 0x6B selects register 2 and 0x6C selects streaming. Any other address leaves both registers and the error output unchanged.
- R3: In a write frame, data bits are shifted in LSB first on clock rising edges. Registers do not change while chip-enable is high. The word is committed within 4 system clocks after the chip-enable falling edge reaches the pins.
- R4: A write frame that carries a number of data bits other than exactly 16 changes neither register nor the error output.
- R5: Register 1 has reserved bits [15:12]. Its correction limit sits in [9:7] and codes 6 and 7 are illegal. Its decision mode sits in [11:10] and code 3 is illegal. Register 2 has reserved bits [15:13]. A word with a nonzero reserved bit or an illegal code is rejected whole and sets the error output to 1. An accepted write sets the error output to 0.
- R6: In a streaming frame, data-out shows bit 31 of the current buffer word once chip-enable is high. Each falling edge that follows a rising edge presents the next bit, MSB first. The 32nd rising edge pulses the take output for one cycle, and streaming carries on into the next word without limit.
- R7: A streaming frame that ends before 32 rising edges does not pulse take. The next streaming frame therefore starts again with bit 31 of the same word.
- R8: Writes and streaming behave identically whether the clock idles low or high.
- R9: Data-out is 1 whenever no streaming frame is open, including while the address is being shifted and during write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip-enable pin: low for address, high for data |
| cl_i | input | 1 | Serial clock pin, either idle polarity |
| di_i | input | 1 | Serial data-in pin |
| do_o | output | 1 | Serial data-out level (1 = released) |
| cfg1_o | output | 16 | Configuration register 1 |
| cfg2_o | output | 16 | Configuration register 2 |
| cfg_err_o | output | 1 | Last completed write was rejected |
| word_i | input | 32 | Current head word of the output buffer |
| word_take_o | output | 1 | One-cycle pulse: head word fully shifted out |

## Verification
The hardest case to reach is a streaming frame that crosses a word boundary. The take pulse and the buffer's change of head word must land between a rising edge and the following falling edge, and the very next bit must already come from the new word. To get there, the bench clocks three whole words inside one chip-enable frame, in each clock polarity. It compares every bit against a buffer model that advances only on take pulses. A truncated frame followed by a full one confirms that an interrupted word is replayed. Rejected writes are then placed between accepted ones, so that both the hold of the register and the clearing of the error are visible.

// File: rtl/sctl_port.sv
module sctl_port #(
  parameter int ADDR_W = 8,
  parameter int CFG_W  = 16,
  parameter int WORD_W = 32,
  parameter logic [ADDR_W-1:0] ADDR_CFG1 = 8'h6A,
  parameter logic [ADDR_W-1:0] ADDR_CFG2 = 8'h6B,
  parameter logic [ADDR_W-1:0] ADDR_STRM = 8'h6C,
  parameter logic [CFG_W-1:0]  CFG1_RST  = 16'h0902,
  parameter logic [CFG_W-1:0]  CFG2_RST  = 16'h0034
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              cl_i,
  input  logic              di_i,
  output logic              do_o,
  output logic [CFG_W-1:0]  cfg1_o,
  output logic [CFG_W-1:0]  cfg2_o,
  output logic              cfg_err_o,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_take_o
);
  localparam int MAXB  = (WORD_W > CFG_W) ? WORD_W : CFG_W;
  localparam int CNT_W = $clog2(MAXB + 2);
  localparam logic [CNT_W-1:0] CFG_END = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] CFG_SAT = CNT_W'(CFG_W + 1);
  localparam logic [CNT_W-1:0] WRD_END = CNT_W'(WORD_W - 1);

  typedef enum logic [1:0] {M_NONE, M_CFG1, M_CFG2, M_STRM} mode_t;

  logic [2:0] ce_q, cl_q;
  logic [1:0] di_q;
  logic [ADDR_W-1:0] addr_sr;
  logic [CFG_W-1:0]  data_sr, cfg1_q, cfg2_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] word_sh;
  mode_t mode_q;
  logic  pend_q, do_bit, err_q, take_q;
  logic  ce_rise, ce_fall, cl_rise, cl_fall, ok1, ok2;

  assign ce_rise = ce_q[1] & ~ce_q[2];
  assign ce_fall = ~ce_q[1] & ce_q[2];
  assign cl_rise = cl_q[1] & ~cl_q[2];
  assign cl_fall = ~cl_q[1] & cl_q[2];
  assign word_sh = word_i << bit_cnt;

  assign ok1 = (data_sr[15:12] == 4'd0) && (data_sr[9:7] <= 3'd5) && (data_sr[11:10] != 2'd3);
  assign ok2 = (data_sr[15:13] == 3'd0);

  assign do_o        = (mode_q == M_STRM) ? do_bit : 1'b1;
  assign cfg1_o      = cfg1_q;
  assign cfg2_o      = cfg2_q;
  assign cfg_err_o   = err_q;
  assign word_take_o = take_q;

  function automatic mode_t dec(input logic [ADDR_W-1:0] a);
    if (a == ADDR_CFG1)      return M_CFG1;
    else if (a == ADDR_CFG2) return M_CFG2;
    else if (a == ADDR_STRM) return M_STRM;
    else                     return M_NONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= '0; cl_q <= '0; di_q <= '0;
    end else begin
      ce_q <= {ce_q[1:0], ce_i};
      cl_q <= {cl_q[1:0], cl_i};
      di_q <= {di_q[0], di_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_sr <= '0; data_sr <= '0; bit_cnt <= '0; mode_q <= M_NONE;
      pend_q <= 1'b0; do_bit <= 1'b1; err_q <= 1'b0; take_q <= 1'b0;
      cfg1_q <= CFG1_RST; cfg2_q <= CFG2_RST;
    end else begin
      take_q <= 1'b0;
      if (ce_rise) begin
        mode_q  <= dec(addr_sr);
        bit_cnt <= '0;
        pend_q  <= 1'b0;
        do_bit  <= word_i[WORD_W-1];
      end else if (ce_fall) begin
        if (bit_cnt == CFG_END && mode_q == M_CFG1) begin
          if (ok1) cfg1_q <= data_sr;
          err_q <= ~ok1;
        end
        if (bit_cnt == CFG_END && mode_q == M_CFG2) begin
          if (ok2) cfg2_q <= data_sr;
          err_q <= ~ok2;
        end
        mode_q <= M_NONE;
      end else if (ce_q[1]) begin
        if (cl_rise) begin
          if (mode_q == M_CFG1 || mode_q == M_CFG2) begin
            data_sr <= {di_q[1], data_sr[CFG_W-1:1]};
            if (bit_cnt != CFG_SAT) bit_cnt <= bit_cnt + 1'b1;
          end else if (mode_q == M_STRM) begin
            pend_q <= 1'b1;
            if (bit_cnt == WRD_END) begin
              bit_cnt <= '0;
              take_q  <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end else if (cl_fall && pend_q && mode_q == M_STRM) begin
          pend_q <= 1'b0;
          do_bit <= word_sh[WORD_W-1];
        end
      end else if (cl_rise) begin
        addr_sr <= {di_q[1], addr_sr[ADDR_W-1:1]};
      end
    end
  end

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(cfg1_q) && $stable(cfg2_q));
  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(err_q));
  p_legal_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg1_q[15:12] == 4'd0 && cfg1_q[9:7] <= 3'd5 && cfg1_q[11:10] != 2'd3 && cfg2_q[15:13] == 3'd0);
  p_take_in_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> mode_q == M_STRM);
  p_take_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);
  p_do_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_q[1] && !ce_q[2]) |-> do_o);
endmodule

// File: tb/sctl_port_bench.sv
`timescale 1ns/1ps
module sctl_port_bench;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, ce = 0, cl = 0, di = 0;
  logic do_w, err, take;
  logic [15:0] c1, c2;
  logic [31:0] word;
  int pops = 0, tests = 0, fails = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] exp_word(input int k);
    return {8'hC3, k[7:0], ~k[7:0], 8'h5A};
  endfunction
  assign word = exp_word(pops);
  always @(posedge clk) if (take) pops <= pops + 1;

  sctl_port u_sctl_port (.clk(clk), .rst_n(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
    .do_o(do_w), .cfg1_o(c1), .cfg2_o(c2), .cfg_err_o(err), .word_i(word), .word_take_o(take));

  // {pol, addr, data, exp cfg1, exp cfg2, exp err}
  localparam logic [57:0] VEC [9] = '{
    {1'b0, 8'h6A, 16'h0285, 16'h0285, 16'h0034, 1'b0},
    {1'b1, 8'h6B, 16'h1FFF, 16'h0285, 16'h1FFF, 1'b0},
    {1'b0, 8'h6A, 16'h0300, 16'h0285, 16'h1FFF, 1'b1},
    {1'b1, 8'h6A, 16'h0C00, 16'h0285, 16'h1FFF, 1'b1},
    {1'b0, 8'h6A, 16'h1000, 16'h0285, 16'h1FFF, 1'b1},
    {1'b1, 8'h6A, 16'h0A7F, 16'h0A7F, 16'h1FFF, 1'b0},
    {1'b0, 8'h6B, 16'h2000, 16'h0A7F, 16'h1FFF, 1'b1},
    {1'b0, 8'h55, 16'hFFFF, 16'h0A7F, 16'h1FFF, 1'b1},
    {1'b1, 8'h6B, 16'h0000, 16'h0A7F, 16'h0000, 1'b0}
  };

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input logic pol);
    di = b;
    if (pol) begin cl = 0; wt(H); cl = 1; wt(H); end
    else begin wt(H); cl = 1; wt(H); cl = 0; end
  endtask

  task automatic get_bit(input logic pol, output logic b);
    if (pol) begin cl = 0; wt(H); b = do_w; cl = 1; wt(H); end
    else begin wt(H); b = do_w; cl = 1; wt(H); cl = 0; end
  endtask

  task automatic open_frame(input logic [7:0] a, input logic pol);
    cl = pol; wt(H);
    for (int i = 0; i < 8; i++) put_bit(a[i], pol);
    chk("R9 released during address", {31'd0, do_w}, 32'd1);
    wt(H); ce = 1; wt(H);
  endtask

  task automatic close_frame();
    wt(H); ce = 0; wt(2*H);
  endtask

  task automatic write_bits(input logic [31:0] d, input int n, input logic pol);
    for (int i = 0; i < n; i++) put_bit(d[i], pol);
  endtask

  task automatic read_word(input logic pol, output logic [31:0] w);
    logic b;
    w = '0;
    for (int i = 0; i < 32; i++) begin get_bit(pol, b); w = {w[30:0], b}; end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] w;
    int p0;
    wt(5);
    chk("R1 cfg1 reset", {16'd0, c1}, 32'h0902);
    chk("R1 cfg2 reset", {16'd0, c2}, 32'h0034);
    chk("R1 err reset", {31'd0, err}, 32'd0);
    chk("R1 do reset", {31'd0, do_w}, 32'd1);
    rst_n = 1; wt(4);

    for (int v = 0; v < 9; v++) begin
      open_frame(VEC[v][56:49], VEC[v][57]);
      write_bits({16'd0, VEC[v][48:33]}, 16, VEC[v][57]);
      chk("R9 released in write frame", {31'd0, do_w}, 32'd1);
      close_frame();
      chk("R2/R5/R8 cfg1", {16'd0, c1}, {16'd0, VEC[v][32:17]});
      chk("R2/R5/R8 cfg2", {16'd0, c2}, {16'd0, VEC[v][16:1]});
      chk("R5 err", {31'd0, err}, {31'd0, VEC[v][0]});
    end

    // R3: nothing before the chip-enable fall, committed within 4 clocks after
    open_frame(8'h6A, 1'b0);
    write_bits(32'h0001, 16, 1'b0);
    wt(4*H);
    chk("R3 no change while CE high", {16'd0, c1}, 32'h0A7F);
    ce = 0; wt(2);
    chk("R3 no change 2 clocks after fall", {16'd0, c1}, 32'h0A7F);
    wt(2);
    chk("R3 committed 4 clocks after fall", {16'd0, c1}, 32'h0001);
    wt(2*H);

    // R4: short and long frames ignored
    open_frame(8'h6A, 1'b1); write_bits(32'h0285, 15, 1'b1); close_frame();
    chk("R4 15-bit frame ignored", {16'd0, c1}, 32'h0001);
    open_frame(8'h6B, 1'b0); write_bits(32'h1_0003, 17, 1'b0); close_frame();
    chk("R4 17-bit frame ignored", {16'd0, c2}, 32'h0000);
    chk("R4 err untouched", {31'd0, err}, 32'd0);

    // R6/R8: three words in one frame, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      p0 = pops;
      open_frame(8'h6C, pol[0]);
      for (int k = 0; k < 3; k++) begin
        read_word(pol[0], w);
        chk(pol ? "R8 stream word idle-high" : "R6 stream word idle-low", w, exp_word(p0 + k));
      end
      close_frame();
      chk("R6 three takes", pops, p0 + 3);
      chk("R9 released after stream", {31'd0, do_w}, 32'd1);
    end

    // R7: interrupted word is replayed
    p0 = pops;
    open_frame(8'h6C, 1'b0);
    for (int i = 0; i < 10; i++) begin logic b; get_bit(1'b0, b); end
    close_frame();
    chk("R7 no take on partial word", pops, p0);
    open_frame(8'h6C, 1'b1);
    read_word(1'b1, w);
    close_frame();
    chk("R7 same word replayed", w, exp_word(p0));
    chk("R7 take after full word", pops, p0 + 1);

    report();
  end
endmodule